// File: doc/BRIEF.md
# Split biquinary decade counter

This block is a decade counter divided into two sections with separate count inputs. A one-bit divide-by-two section toggles on each falling edge of its count input. A three-bit divide-by-five section steps through five codes on each falling edge of its own count input. The count inputs are ordinary sampled signals on the system clock. A falling edge is recognised when two consecutive clock samples read high and then low.

Outside wiring joins the two sections. If the divide-by-two output feeds the divide-by-five input, the combined output counts in plain BCD. If the top bit of the divide-by-five section feeds the divide-by-two input, the output is bi-quinary, and the divide-by-two output becomes a symmetric square wave at one tenth of the input event rate.

Two gated control pairs act on every clock edge for as long as they are held. One pair forces the count to zero. The other pair forces it to nine and takes priority over the zero pair. No count event is acted on while either force is active.

Top module: `biquinary_counter`

## Requirements
- R1: While rst_ni is low, and after it is released, half_o is 0 and quin_o is 3'b000.
- R2: half_o inverts once for each falling edge seen on tick2_i. tick5_i never changes half_o.
- R3: quin_o advances 000, 001, 010, 011, 100 and then back to 000, once for each falling edge seen on tick5_i. tick2_i never changes quin_o.
- R4: A count input that is sampled high at one rising clock edge and low at the next changes its output at the rising edge after that, which is the second edge that sees it low. A rising transition, or a level held steady, changes nothing.
- R5: If half_o is wired to tick5_i and n events are applied on tick2_i, {quin_o, half_o} read as a 4-bit number equals n mod 10.
- R6: If quin_o[2] is wired to tick2_i and n events are applied on tick5_i, quin_o equals n mod 5, and half_o is 1 exactly when n mod 10 is 5 or more.
- R7: While clr_a_i and clr_b_i are both high and nine_a_i and nine_b_i are not both high, every output is 0 at the next clock edge. One clear input alone has no effect.
- R8: While nine_a_i and nine_b_i are both high, the next clock edge gives half_o=1 and quin_o=3'b100, whatever the clear inputs are. One nine input alone has no effect.
- R9: A falling edge on a count input is discarded if its action edge occurs while either force is active. It does not take effect after the force is released.
- R10: quin_o never holds 101, 110 or 111. If the divide-by-five state is ever found in one of these codes, the next count event returns it to 000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick2_i | input | 1 | Count input of the divide-by-two section |
| tick5_i | input | 1 | Count input of the divide-by-five section |
| clr_a_i | input | 1 | Force-to-zero gate, first input |
| clr_b_i | input | 1 | Force-to-zero gate, second input |
| nine_a_i | input | 1 | Force-to-nine gate, first input |
| nine_b_i | input | 1 | Force-to-nine gate, second input |
| half_o | output | 1 | Divide-by-two section output |
| quin_o | output | 3 | Divide-by-five section state |

## Verification
Two collisions can happen on the same clock edge. In the first, a count event lands on an edge where a force is active. The bench provokes this by dropping tick2_i in the same cycle as the nine pair rises, and it passes only if the forced value 1001 is still there after release. In the second, the clear and nine pairs are both asserted at once, and the bench passes only if nine wins.

// File: rtl/bq_pkg.sv
package bq_pkg;
  localparam int QUIN_W   = 3;
  localparam int QUIN_MOD = 5;
  localparam int N_TICK   = 2;

  typedef enum logic [1:0] {
    FORCE_NONE = 2'd0,
    FORCE_ZERO = 2'd1,
    FORCE_NINE = 2'd2
  } force_e;
endpackage

// File: rtl/fall_detect.sv
module fall_detect #(
  parameter int N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] fall_o
);
  for (genvar g = 0; g < N; g++) begin : g_ch
    logic cur_q, prev_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cur_q  <= 1'b0;
        prev_q <= 1'b0;
      end else begin
        cur_q  <= lvl_i[g];
        prev_q <= cur_q;
      end
    end
    assign fall_o[g] = prev_q & ~cur_q;

    // two events need a high sample in between
    assert_no_back_to_back_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fall_o[g] |=> !fall_o[g]);
  end
endmodule

// File: rtl/div2_stage.sv
module div2_stage
  import bq_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   ev_i,
  input  force_e force_i,
  output logic   q_o
);
  logic q_q, q_d;

  always_comb begin
    unique case (force_i)
      FORCE_ZERO: q_d = 1'b0;
      FORCE_NINE: q_d = 1'b1;
      default:    q_d = ev_i ? ~q_q : q_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= 1'b0;
    else         q_q <= q_d;
  end

  assign q_o = q_q;

  assert_toggle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_i && force_i == FORCE_NONE) |=> (q_o != $past(q_o)));
  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ev_i && force_i == FORCE_NONE) |=> $stable(q_o));
endmodule

// File: rtl/div5_stage.sv
module div5_stage
  import bq_pkg::*;
#(
  parameter int W   = QUIN_W,
  parameter int MOD = QUIN_MOD
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ev_i,
  input  force_e       force_i,
  output logic [W-1:0] q_o
);
  localparam logic [W-1:0] LAST = W'(MOD - 1);

  logic [W-1:0] q_q, q_d;

  always_comb begin
    unique case (force_i)
      FORCE_ZERO: q_d = '0;
      FORCE_NINE: q_d = LAST;
      default: begin
        if (!ev_i)          q_d = q_q;
        else if (q_q >= LAST) q_d = '0;  // wrap, also escapes unused codes
        else                q_d = q_q + 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= '0;
    else         q_q <= q_d;
  end

  assign q_o = q_q;

  assert_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_i && force_i == FORCE_NONE && q_o < LAST) |=> (q_o == $past(q_o) + 1'b1));
  assert_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_i && force_i == FORCE_NONE && q_o == LAST) |=> (q_o == '0));
  assert_legal_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_o <= LAST);
endmodule

// File: rtl/biquinary_counter.sv
module biquinary_counter
  import bq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick2_i,
  input  logic              tick5_i,
  input  logic              clr_a_i,
  input  logic              clr_b_i,
  input  logic              nine_a_i,
  input  logic              nine_b_i,
  output logic              half_o,
  output logic [QUIN_W-1:0] quin_o
);
  force_e            force_mode;
  logic [N_TICK-1:0] fall;

  // nine beats zero
  always_comb begin
    if (nine_a_i && nine_b_i)      force_mode = FORCE_NINE;
    else if (clr_a_i && clr_b_i)   force_mode = FORCE_ZERO;
    else                           force_mode = FORCE_NONE;
  end

  fall_detect #(.N(N_TICK)) u_fall (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  ({tick5_i, tick2_i}),
    .fall_o (fall)
  );

  div2_stage u_div2 (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ev_i    (fall[0]),
    .force_i (force_mode),
    .q_o     (half_o)
  );

  div5_stage #(.W(QUIN_W), .MOD(QUIN_MOD)) u_div5 (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ev_i    (fall[1]),
    .force_i (force_mode),
    .q_o     (quin_o)
  );

  assert_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_a_i && clr_b_i && !(nine_a_i && nine_b_i)) |=> (!half_o && quin_o == '0));
  assert_nine_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nine_a_i && nine_b_i) |=> (half_o && quin_o == QUIN_W'(QUIN_MOD - 1)));
endmodule

// File: tb/tb_biquinary_counter.sv
`timescale 1ns/1ps
module tb_biquinary_counter;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic ext_a = 1'b0, ext_b = 1'b0;
  logic clr_a = 1'b0, clr_b = 1'b0, nine_a = 1'b0, nine_b = 1'b0;
  logic tick2, tick5, half;
  logic [2:0] quin;
  int   mode = 0;  // 0 split, 1 bcd, 2 biquinary
  int   checks = 0, fails = 0;
  bit   done = 1'b0;

  always #2.5 clk = ~clk;

  always_comb begin
    tick2 = (mode == 2) ? quin[2] : ext_a;
    tick5 = (mode == 1) ? half    : ext_b;
  end

  biquinary_counter dut (
    .clk_i(clk), .rst_ni(rst_ni), .tick2_i(tick2), .tick5_i(tick5),
    .clr_a_i(clr_a), .clr_b_i(clr_b), .nine_a_i(nine_a), .nine_b_i(nine_b),
    .half_o(half), .quin_o(quin)
  );

  function automatic int val();
    return int'({quin, half});
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic pulse_a();
    @(negedge clk) ext_a = 1'b1;
    repeat (3) @(negedge clk);
    ext_a = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse_b();
    @(negedge clk) ext_b = 1'b1;
    repeat (3) @(negedge clk);
    ext_b = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic zero_all();
    @(negedge clk);
    mode = 0; ext_a = 0; ext_b = 0;
    clr_a = 1; clr_b = 1;
    repeat (4) @(negedge clk);
    clr_a = 0; clr_b = 0;
    settle();
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check("R1 during reset", val(), 0);
    rst_ni = 1'b1;
    settle();
    check("R1 after reset", val(), 0);
  endtask

  task automatic t_split();
    zero_all();
    for (int i = 1; i <= 3; i++) begin
      pulse_a(); settle();
      check("R2 toggle", int'(half), i % 2);
      check("R3 unaffected by tick2", int'(quin), 0);
    end
    for (int i = 1; i <= 7; i++) begin
      pulse_b(); settle();
      check("R3 step", int'(quin), i % 5);
      check("R2 unaffected by tick5", int'(half), 1);
    end
  endtask

  task automatic t_latency();
    zero_all();
    @(negedge clk) ext_a = 1'b1;
    repeat (4) @(negedge clk);
    check("R4 rising edge no effect", int'(half), 0);
    ext_a = 1'b0;
    @(posedge clk); #1;
    check("R4 first edge low", int'(half), 0);
    @(posedge clk); #1;
    check("R4 second edge low", int'(half), 1);
    repeat (5) @(negedge clk);
    check("R4 steady low", int'(half), 1);
  endtask

  task automatic t_bcd();
    zero_all();
    mode = 1;
    for (int n = 1; n <= 12; n++) begin
      pulse_a(); settle();
      check("R5 bcd", val(), n % 10);
    end
  endtask

  task automatic t_biq();
    zero_all();
    mode = 2;
    for (int n = 1; n <= 12; n++) begin
      pulse_b(); settle();
      check("R6 quin", int'(quin), n % 5);
      check("R6 half", int'(half), ((n % 10) >= 5) ? 1 : 0);
    end
  endtask

  task automatic t_clear();
    zero_all();
    pulse_a(); pulse_b(); pulse_b(); settle();  // value 0101
    @(negedge clk) clr_a = 1;
    settle();
    check("R7 single clear ignored", val(), 5);
    clr_a = 0; clr_b = 1;
    settle();
    check("R7 single clear ignored", val(), 5);
    clr_a = 1;
    @(posedge clk); #1;
    check("R7 clear next edge", val(), 0);
    @(negedge clk) clr_a = 0; clr_b = 0;
  endtask

  task automatic t_nine();
    zero_all();
    @(negedge clk) nine_a = 1;
    settle();
    check("R8 single nine ignored", val(), 0);
    nine_a = 0; nine_b = 1;
    settle();
    check("R8 single nine ignored", val(), 0);
    nine_a = 1; clr_a = 1; clr_b = 1;
    @(posedge clk); #1;
    check("R8 nine over clear", val(), 9);
    @(negedge clk) nine_a = 0; nine_b = 0; clr_a = 0; clr_b = 0;
    settle();
  endtask

  task automatic t_suppress();
    zero_all();
    @(negedge clk) ext_a = 1; ext_b = 1;
    repeat (3) @(negedge clk);
    // fall and force begin together
    ext_a = 0; nine_a = 1; nine_b = 1;
    repeat (3) @(negedge clk);
    ext_b = 0;
    repeat (4) @(negedge clk);
    nine_a = 0; nine_b = 0;
    settle();
    check("R9 events lost under force", val(), 9);
    pulse_a(); settle();
    check("R9 counting resumes", val(), 8);
    pulse_b(); settle();
    check("R3 wrap from 100", int'(quin), 0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_split();
    t_latency();
    t_bcd();
    t_biq();
    t_clear();
    t_nine();
    t_suppress();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule